// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns parallel characters into an asynchronous serial stream. Characters enter through a write strobe with a 12-bit data word and wait in a small queue. The queue can be cut down to a single holding slot. Each character goes out as a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop period. The word length runs from 5 to 12 bits. The parity mode is selected by a 3-bit code. The total frame length is given as a count of 16x baud ticks minus one, so stop periods of one, one and a half or two bits can all be expressed.

Timing is driven by a 16x baud clock-enable that comes from outside the block, and each bit lasts 16 enabled cycles. A clear-to-send input gates the start of every new character. A break input forces the line low and holds back new characters while it is high. The serial output is registered. It changes one clock after the tick cycle that moves the frame forward.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset `txd` is 1, `empty` is 1, `full` is 0 and `count` is 0. Whenever no frame is in progress and `brk` is low, `txd` is 1.
- R2: A frame starts with one low start bit. The `word_len` data bits follow, least significant bit first. Every bit lasts 16 cycles in which `tick16` is high, and the frame advances only in such cycles.
- R3: `par_mode` selects the parity bit, which follows the last data bit. Code 000 sends no parity bit. Code 001 sends odd parity and code 011 sends even parity, both taken over the `word_len` data bits. Code 101 sends a constant 1 and code 111 sends a constant 0. A parity bit is sent whenever bit 0 of the code is 1.
- R4: After the parity bit, or after the last data bit when there is no parity, the line stays high until the frame has lasted `frame_ticks`+1 ticks. When characters are queued back to back, each start bit begins exactly `frame_ticks`+1 ticks after the one before, which allows half-bit stop lengths.
- R5: A character starts only in a tick cycle in which `cts` is 1. While `cts` is 0, queued characters stay in the queue.
- R6: When `cts` falls during a frame, that frame still completes unchanged, and no further character starts.
- R7: One clock after `brk` goes high, `txd` is 0, and it stays 0 while `brk` is high. No character starts while `brk` is high.
- R8: With `fifo_en`=1 the queue holds up to DEPTH characters and sends them in the order they were written. `count` reports the occupancy, and `full` is 1 exactly when `count` equals DEPTH.
- R9: A write while `full` is 1 is dropped. It does not change `count` and does not disturb the queued characters.
- R10: With `fifo_en`=0 the queue holds a single character: `full` is 1 once one character is held.
- R11: A one-cycle `fifo_clr` pulse empties the queue, and the discarded characters are never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | DATA_W (12) | Character to queue, right-aligned |
| fifo_en | input | 1 | 1: full queue depth, 0: single holding slot |
| fifo_clr | input | 1 | Discard all queued characters |
| word_len | input | 4 | Number of data bits, 5 to 12 |
| par_mode | input | 3 | Parity code (see R3) |
| frame_ticks | input | FT_W (9) | Frame length in 16x ticks, minus one |
| tick16 | input | 1 | 16x baud clock-enable |
| cts | input | 1 | Clear-to-send, active high |
| brk | input | 1 | Force line low |
| txd | output | 1 | Serial output, idle high |
| full | output | 1 | Queue cannot take a write |
| empty | output | 1 | Queue holds no character |
| count | output | CNT_W (5) | Characters in queue |

## Verification
The bench checks the handover from one frame to the next. A sequencer that inserted one idle tick between frames, or that ended each frame one tick early, would throw off the measured start-to-start spacing for both the whole-bit and the half-bit stop lengths. The bench covers every parity code, including the forced codes and the 5-bit and 12-bit widths. A design that used the wrong polarity or counted parity over unused high bits would decode a wrong parity bit. The bench also drops clear-to-send in the middle of a frame, drives writes into a full queue and into the single-slot mode, and clears a queue that holds characters. A design that cut a frame short, overwrote queued data or leaked cleared characters would produce a mismatched or unexpected frame.

// File: rtl/utx_pkg.sv
package utx_pkg;

  // Number of 16x ticks in one bit period.
  localparam int unsigned TICKS_PER_BIT = 16;
  localparam int unsigned TICK_SHIFT    = 4;

  // Upper two bits of the parity code; bit 0 enables the parity slot.
  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } par_kind_e;

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              deep,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic              push, pop;

  assign empty = (count == '0);
  assign full  = deep ? (count == CW'(DEPTH)) : (count != '0);
  assign push  = wr && !full && !clr;
  assign pop   = rd && !empty && !clr;

  // Storage without reset so a RAM can be inferred.
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned FT_W   = 9,
  localparam int unsigned WL_W  = $clog2(DATA_W + 1),
  localparam int unsigned SLOT_W = FT_W - TICK_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cts,
  input  logic              brk,
  input  logic              avail,
  input  logic [DATA_W-1:0] din,
  input  logic [WL_W-1:0]   word_len,
  input  logic [2:0]        par_mode,
  input  logic [FT_W-1:0]   frame_ticks,
  output logic              take,
  output logic              busy,
  output logic              txd
);

  logic [DATA_W-1:0] shreg;
  logic [FT_W-1:0]   tcnt, tnext;
  logic [SLOT_W-1:0] slot;
  logic              par_q, lvl, slot_lvl, at_end, can_start;
  logic [DATA_W-1:0] sh;

  function automatic logic calc_par(input logic [DATA_W-1:0] d,
                                    input logic [WL_W-1:0]   wl,
                                    input logic [2:0]        m);
    logic x;
    x = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(wl)) x = x ^ d[i];
    end
    case (par_kind_e'(m[2:1]))
      PAR_ODD:  return ~x;
      PAR_EVEN: return x;
      PAR_MARK: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  assign can_start = avail && cts && !brk;
  assign at_end    = busy && (tcnt == frame_ticks);
  assign take      = tick && can_start && (!busy || at_end);
  assign tnext     = tcnt + FT_W'(1);
  assign slot      = tnext[FT_W-1:TICK_SHIFT];

  // Line level for the tick position that follows the current one.
  always_comb begin
    sh = shreg >> (slot - SLOT_W'(1));
    if (slot == '0)
      slot_lvl = 1'b0;
    else if (slot <= SLOT_W'(word_len))
      slot_lvl = sh[0];
    else if ((slot == SLOT_W'(word_len) + SLOT_W'(1)) && par_mode[0])
      slot_lvl = par_q;
    else
      slot_lvl = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      tcnt  <= '0;
      lvl   <= 1'b1;
      shreg <= '0;
      par_q <= 1'b0;
    end else if (tick) begin
      if (take) begin
        busy  <= 1'b1;
        tcnt  <= '0;
        lvl   <= 1'b0;
        shreg <= din;
        par_q <= calc_par(din, word_len, par_mode);
      end else if (at_end) begin
        busy <= 1'b0;
        lvl  <= 1'b1;
      end else if (busy) begin
        tcnt <= tnext;
        lvl  <= slot_lvl;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else     txd <= lvl && !brk;
  end

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned FT_W   = 9,
  localparam int unsigned WL_W  = $clog2(DATA_W + 1),
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fifo_en,
  input  logic              fifo_clr,
  input  logic [WL_W-1:0]   word_len,
  input  logic [2:0]        par_mode,
  input  logic [FT_W-1:0]   frame_ticks,
  input  logic              tick16,
  input  logic              cts,
  input  logic              brk,
  output logic              txd,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] q_data;
  logic              tx_take, tx_busy;

  utx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (fifo_clr),
    .deep  (fifo_en),
    .wr    (wr_en),
    .wdata (wr_data),
    .rd    (tx_take),
    .rdata (q_data),
    .full  (full),
    .empty (empty),
    .count (count)
  );

  utx_shifter #(.DATA_W(DATA_W), .FT_W(FT_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick16),
    .cts         (cts),
    .brk         (brk),
    .avail       (!empty && !fifo_clr),
    .din         (q_data),
    .word_len    (word_len),
    .par_mode    (par_mode),
    .frame_ticks (frame_ticks),
    .take        (tx_take),
    .busy        (tx_busy),
    .txd         (txd)
  );

endmodule

// File: rtl/uart_tx_engine_chk.sv
module uart_tx_engine_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             fifo_clr,
  input logic             brk,
  input logic             cts,
  input logic             txd,
  input logic             full,
  input logic             empty,
  input logic [CNT_W-1:0] count,
  input logic             busy,
  input logic             take
);

  // R7: line low one clock after break is requested
  a_r7_break_low: assert property (@(posedge clk) disable iff (rst)
    brk |=> !txd);

  // R1: idle line is high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    (!busy && !brk) |=> txd);

  // R5: a frame begins only after clear-to-send was high
  a_r5_cts_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cts));

  // R2: first bit on the line is the low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !brk) |=> !txd);

  // R9: write into a full queue leaves occupancy unchanged
  a_r9_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !take && !fifo_clr) |=> $stable(count));

  // R11: clear empties the queue
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> (empty && count == '0));

  // R8: occupancy never exceeds the depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

endmodule

bind uart_tx_engine uart_tx_engine_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .fifo_clr (fifo_clr),
  .brk      (brk),
  .cts      (cts),
  .txd      (txd),
  .full     (full),
  .empty    (empty),
  .count    (count),
  .busy     (tx_busy),
  .take     (tx_take)
);

// File: tb/test_uart_tx_engine.sv
module test_uart_tx_engine;

  localparam int CLK_P = 10;
  localparam int TDIV  = 4;
  localparam int CPB   = 16 * TDIV;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst, wr_en, fifo_en, fifo_clr, tick16, cts, brk;
  logic [11:0] wr_data;
  logic [3:0]  word_len;
  logic [2:0]  par_mode;
  logic [8:0]  frame_ticks;
  logic        txd, full, empty;
  logic [4:0]  count;

  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0, mon_en = 1'b0;
  longint      cyc = 0;
  logic [11:0] exp_q[$];
  longint      starts[$];
  logic [11:0] got, e;
  logic        gp;
  int          mwl;
  logic [2:0]  mpm;

  uart_tx_engine #(.DATA_W(12), .DEPTH(DEPTH), .FT_W(9)) i_uart_tx_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_en(fifo_en), .fifo_clr(fifo_clr), .word_len(word_len),
    .par_mode(par_mode), .frame_ticks(frame_ticks), .tick16(tick16),
    .cts(cts), .brk(brk), .txd(txd), .full(full), .empty(empty),
    .count(count)
  );

  always #(CLK_P / 2) clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial begin
    tick16 = 1'b0;
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic ref_par(input logic [11:0] d, input int wl, input logic [2:0] pm);
    int ones = 0;
    for (int i = 0; i < wl; i++) ones += d[i];
    case (pm)
      3'b001:  return (ones % 2) == 0;
      3'b011:  return (ones % 2) == 1;
      3'b101:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Monitor: decodes frames from txd and compares them with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && txd === 1'b0) begin
        starts.push_back(cyc);
        mwl = int'(word_len);
        mpm = par_mode;
        got = '0;
        gp  = 1'b0;
        repeat (CPB / 2) @(negedge clk);
        check(txd === 1'b0, "R2 start bit", txd, 0);
        for (int i = 0; i < mwl; i++) begin
          repeat (CPB) @(negedge clk);
          got[i] = txd;
        end
        if (mpm[0]) begin
          repeat (CPB) @(negedge clk);
          gp = txd;
        end
        repeat (CPB) @(negedge clk);
        check(txd === 1'b1, "R4 stop level", txd, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected frame", got, -1);
        end else begin
          e = exp_q.pop_front() & ((12'h1 << mwl) - 12'h1);
          check(got == e, "R2 data bits", got, e);
          if (mpm[0]) check(gp == ref_par(e, mwl, mpm), "R3 parity bit", gp, ref_par(e, mwl, mpm));
        end
      end
    end
  end

  task automatic setcfg(input int wl, input logic [2:0] pm, input int stop_halves);
    word_len    = 4'(wl);
    par_mode    = pm;
    frame_ticks = 9'(16 * (1 + wl + int'(pm[0])) + 8 * stop_halves - 1);
  endtask

  task automatic send(input logic [11:0] d, input bit accept);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    if (accept) exp_q.push_back(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    wait (empty === 1'b1);
    repeat ((int'(frame_ticks) + 1) * TDIV + 40) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; fifo_en = 1'b1; fifo_clr = 1'b0;
    cts = 1'b1; brk = 1'b0;
    setcfg(8, 3'b000, 2);
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(txd === 1'b1, "R1 txd", txd, 1);
    check(empty === 1'b1, "R1 empty", empty, 1);
    check(full === 1'b0, "R1 full", full, 0);
    check(count == 0, "R1 count", count, 0);
    mon_en = 1'b1;

    // R2 / R4: 8N1 back-to-back frames
    starts.delete();
    send(12'h055, 1); send(12'h0A3, 1); send(12'h000, 1); send(12'h0FF, 1);
    drain();
    check(exp_q.size() == 0, "R2 all received", exp_q.size(), 0);
    check(starts.size() == 4, "R4 frame count", starts.size(), 4);
    if (starts.size() == 4) begin
      check(starts[1] - starts[0] == 160 * TDIV, "R4 spacing", starts[1] - starts[0], 160 * TDIV);
      check(starts[3] - starts[2] == 160 * TDIV, "R4 spacing", starts[3] - starts[2], 160 * TDIV);
    end

    // R3: each parity code at several widths
    setcfg(5, 3'b001, 2);  send(12'h013, 1); send(12'h01F, 1); drain();
    setcfg(12, 3'b011, 2); send(12'hABC, 1); send(12'h800, 1); drain();
    setcfg(7, 3'b101, 2);  send(12'h03C, 1); drain();
    setcfg(9, 3'b111, 2);  send(12'h1A5, 1); drain();
    check(exp_q.size() == 0, "R3 all received", exp_q.size(), 0);

    // R4: one and a half stop bits, then two stop bits with parity
    setcfg(5, 3'b000, 3);
    starts.delete();
    send(12'h00A, 1); send(12'h015, 1); drain();
    check(starts.size() == 2 && starts[1] - starts[0] == 120 * TDIV, "R4 half stop",
          starts.size() == 2 ? starts[1] - starts[0] : 0, 120 * TDIV);
    setcfg(6, 3'b011, 4);
    starts.delete();
    send(12'h02D, 1); send(12'h012, 1); drain();
    check(starts.size() == 2 && starts[1] - starts[0] == 160 * TDIV, "R4 two stop",
          starts.size() == 2 ? starts[1] - starts[0] : 0, 160 * TDIV);

    // R5: no start while cts low
    setcfg(8, 3'b000, 2);
    cts = 1'b0;
    starts.delete();
    send(12'h05A, 1);
    repeat (1500) @(negedge clk);
    check(starts.size() == 0, "R5 held", starts.size(), 0);
    check(count == 1, "R5 queued", count, 1);
    cts = 1'b1;
    drain();
    check(starts.size() == 1 && exp_q.size() == 0, "R5 released", starts.size(), 1);

    // R6: cts drops mid-frame
    starts.delete();
    send(12'h081, 1); send(12'h07E, 1);
    wait (starts.size() == 1);
    repeat (200) @(negedge clk);
    cts = 1'b0;
    repeat (1500) @(negedge clk);
    check(starts.size() == 1, "R6 no second start", starts.size(), 1);
    check(exp_q.size() == 1, "R6 first completed", exp_q.size(), 1);
    check(count == 1, "R6 second queued", count, 1);
    cts = 1'b1;
    drain();
    check(starts.size() == 2, "R6 second sent", starts.size(), 2);

    // R7: break
    mon_en = 1'b0;
    @(negedge clk) brk = 1'b1;
    repeat (3) @(negedge clk);
    check(txd === 1'b0, "R7 low", txd, 0);
    send(12'h033, 1);
    repeat (800) @(negedge clk);
    check(txd === 1'b0, "R7 still low", txd, 0);
    check(count == 1, "R7 no start", count, 1);
    brk = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R7 released high", txd, 1);
    mon_en = 1'b1;
    drain();
    check(exp_q.size() == 0, "R7 char after break", exp_q.size(), 0);

    // R8 / R9: fill the queue, then overflow
    cts = 1'b0;
    for (int i = 0; i < DEPTH; i++) send(12'(i * 7 + 1), 1);
    @(negedge clk);
    check(full === 1'b1, "R8 full", full, 1);
    check(count == DEPTH, "R8 count", count, DEPTH);
    send(12'h0EE, 0); send(12'h0DD, 0);
    @(negedge clk);
    check(count == DEPTH, "R9 count unchanged", count, DEPTH);
    cts = 1'b1;
    drain();
    check(exp_q.size() == 0, "R8 order", exp_q.size(), 0);

    // R10: single holding slot
    cts = 1'b0;
    fifo_en = 1'b0;
    send(12'h04B, 1);
    @(negedge clk);
    check(full === 1'b1 && count == 1, "R10 full at one", count, 1);
    send(12'h099, 0);
    @(negedge clk);
    check(count == 1, "R10 second dropped", count, 1);
    starts.delete();
    cts = 1'b1;
    drain();
    check(starts.size() == 1 && exp_q.size() == 0, "R10 one frame", starts.size(), 1);
    fifo_en = 1'b1;

    // R11: clear discards queued characters
    cts = 1'b0;
    send(12'h011, 0); send(12'h022, 0); send(12'h044, 0);
    @(negedge clk) fifo_clr = 1'b1;
    @(negedge clk) fifo_clr = 1'b0;
    check(empty === 1'b1 && count == 0, "R11 emptied", count, 0);
    starts.delete();
    cts = 1'b1;
    repeat (1500) @(negedge clk);
    check(starts.size() == 0, "R11 nothing sent", starts.size(), 0);
    check(txd === 1'b1, "R1 idle after clear", txd, 1);

    done = 1'b1;
    finish_run();
  end

endmodule